// File: doc/BRIEF.md
# Device Power State Controller

This block keeps the power management state of a bus-attached network device and decides, from that state, whether the device may take part in bus traffic. Software moves the device between power levels by writing a two-bit target field into the power control register. Base address programming brings a freshly reset device from its uninitialized full-power substate into active operation. A loss of main power while the device is in its software-requested deepest state drops it into the unpowered state. Only a power-on reset leaves that state.

Wake sources come in as a vector of one-cycle event pulses. The top wires a link status change and an interesting-packet match into that vector. An event seen in a state that can wake, with wake enabled, sets a sticky status bit. The active-low wake output is driven while both the enable bit and the status bit are set. Software clears the status bit by writing one to it.

States, with their `pwr_state` codes: `PS_D0U` (0, full power, not yet configured), `PS_D0A` (1, full power, active), `PS_D1` (2), `PS_D2` (3), `PS_D3H` (4, deepest state with main power), `PS_D3C` (5, main power gone).

Transitions:
- D0U to D0A on a base address write.
- D0U or D0A to D1, D2 or D3H on a register write.
- D1 to D2 or D3H, and D2 to D3H, on a register write.
- D1 or D2 to D0A on a write of the D0 code.
- D3H to D0U on a write of the D0 code.
- D3H to D3C when main power drops.
- Any state to D0U on reset.

Top module: `pwr_state_ctrl`

## Requirements
- R1: While `rst_n` is low on a clock edge the state becomes D0U (code 0). If `aux_pwr` is low at that edge, `pme_en` and `pme_status` clear and `pme_n` reads 1.
- R2: A reset taken while `aux_pwr` is high keeps `pme_en` and `pme_status`, and so keeps `pme_n`.
- R3: `bar_wr` in D0U moves the state to D0A on the next edge. `bar_wr` in any other state has no effect.
- R4: `cfg_pstate` encodes 0=D0, 1=D1, 2=D2, 3=D3hot. From D0U or D0A a write of 1, 2 or 3 moves to D1, D2 or D3H. A write from D1 or D2 to a higher-power non-D0 level is ignored. In D3H only a write of 0 acts.
- R5: A write of 0 returns D1 or D2 to D0A. It returns D3H to D0U. It leaves D0U and D0A unchanged.
- R6: `main_pwr` low in D3H gives D3C on the next edge. In D3C, register writes and `bar_wr` are ignored until reset.
- R7: `txn_accept` is high only with `txn_req`. Non-configuration requests (`txn_cfg`=0) are accepted only in D0U and D0A. Configuration requests are accepted in every state except D3C. The output is combinational.
- R8: Every register write outside D3C loads `pme_en` from `cfg_pme_en`.
- R9: A `link_chg` or `pkt_match` pulse in D0A, D1, D2 or D3H with `pme_en` set raises `pme_status` on the next edge. `pme_n` is low exactly when `pme_en` and `pme_status` are both 1.
- R10: Wake events in D0U are ignored. In D3C they set `pme_status` only while `aux_pwr` is high.
- R11: `pme_status` holds until a register write with `cfg_pme_clr`=1 outside D3C. A wake event in the same cycle as the clear wins, so the status stays set.
- R12: With `pme_en` clear, wake events do not set `pme_status`, and `pme_n` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, synchronous |
| main_pwr | input | 1 | Main supply present |
| aux_pwr | input | 1 | Auxiliary supply present |
| cfg_wr | input | 1 | Write strobe for the power control register |
| cfg_pstate | input | 2 | Requested power state field |
| cfg_pme_en | input | 1 | Wake enable value written |
| cfg_pme_clr | input | 1 | Write one to clear wake status |
| bar_wr | input | 1 | Base address register programmed |
| link_chg | input | 1 | Link status change pulse |
| pkt_match | input | 1 | Interesting packet pulse |
| txn_req | input | 1 | Bus transaction targets this device |
| txn_cfg | input | 1 | The transaction is a configuration access |
| txn_accept | output | 1 | Transaction may be serviced |
| pwr_state | output | 3 | Current state code |
| pme_en | output | 1 | Wake enable bit |
| pme_status | output | 1 | Wake status bit |
| pme_n | output | 1 | Wake indication, active low |

## Verification
The bench builds the block with its default of two wake sources: bit 0 is the link change and bit 1 is the packet match. Both sources can therefore be driven through their own ports, and each source is shown to set the status bit. Every one of the six states is reached by its legal paths, including the main-power drop into D3C. From those states the bench tries refused upward moves, clear-against-set collisions and resets with and without auxiliary power.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
    localparam int PS_W   = 3;
    localparam int CODE_W = 2;

    typedef enum logic [PS_W-1:0] {
        PS_D0U = 3'd0,
        PS_D0A = 3'd1,
        PS_D1  = 3'd2,
        PS_D2  = 3'd3,
        PS_D3H = 3'd4,
        PS_D3C = 3'd5
    } pstate_e;

    localparam logic [CODE_W-1:0] REQ_D0 = 2'd0;
    localparam logic [CODE_W-1:0] REQ_D1 = 2'd1;
    localparam logic [CODE_W-1:0] REQ_D2 = 2'd2;
    localparam logic [CODE_W-1:0] REQ_D3 = 2'd3;
endpackage

// File: rtl/pwr_fsm.sv
module pwr_fsm
    import pwr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              main_pwr,
    input  logic              cfg_wr,
    input  logic [CODE_W-1:0] cfg_code,
    input  logic              bar_wr,
    output pstate_e           state
);
    pstate_e nxt;

    // Register value for a request code taken from a full-power state.
    function automatic pstate_e low_target(input logic [CODE_W-1:0] c);
        unique case (c)
            REQ_D1:  return PS_D1;
            REQ_D2:  return PS_D2;
            default: return PS_D3H;
        endcase
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) state <= PS_D0U;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            PS_D0U: begin
                if (cfg_wr && cfg_code != REQ_D0) nxt = low_target(cfg_code);
                else if (bar_wr)                  nxt = PS_D0A;
            end
            PS_D0A: begin
                if (cfg_wr && cfg_code != REQ_D0) nxt = low_target(cfg_code);
            end
            PS_D1: begin
                if (cfg_wr) begin
                    if (cfg_code == REQ_D0)      nxt = PS_D0A;
                    else if (cfg_code == REQ_D2) nxt = PS_D2;
                    else if (cfg_code == REQ_D3) nxt = PS_D3H;
                end
            end
            PS_D2: begin
                if (cfg_wr) begin
                    if (cfg_code == REQ_D0)      nxt = PS_D0A;
                    else if (cfg_code == REQ_D3) nxt = PS_D3H;
                end
            end
            PS_D3H: begin
                if (!main_pwr)                            nxt = PS_D3C;
                else if (cfg_wr && cfg_code == REQ_D0)    nxt = PS_D0U;
            end
            PS_D3C:  nxt = PS_D3C;
            default: nxt = PS_D0U;
        endcase
    end

    assert_bar_promotes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_D0U && bar_wr && !cfg_wr) |=> (state == PS_D0A));
    assert_power_loss_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_D3H && !main_pwr) |=> (state == PS_D3C));
    assert_cold_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_D3C) |=> (state == PS_D3C));
    assert_no_upward_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_D2 && cfg_wr && cfg_code == REQ_D1) |=> (state == PS_D2));
endmodule

// File: rtl/pme_ctrl.sv
module pme_ctrl
    import pwr_pkg::*;
#(
    parameter int N_SRC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             aux_pwr,
    input  pstate_e          state,
    input  logic             cfg_wr,
    input  logic             cfg_pme_en,
    input  logic             cfg_pme_clr,
    input  logic [N_SRC-1:0] wake_src,
    output logic             pme_en,
    output logic             pme_status,
    output logic             pme_n
);
    logic wake_ok, cfg_ok, set_ev, clr_ev;

    always_comb begin
        unique case (state)
            PS_D0A, PS_D1, PS_D2, PS_D3H: wake_ok = 1'b1;
            PS_D3C:                       wake_ok = aux_pwr;
            default:                      wake_ok = 1'b0;
        endcase
        cfg_ok = cfg_wr && (state != PS_D3C);
        set_ev = (|wake_src) && pme_en && wake_ok;
        clr_ev = cfg_ok && cfg_pme_clr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            if (!aux_pwr) begin
                pme_en     <= 1'b0;
                pme_status <= 1'b0;
            end
        end else begin
            if (cfg_ok) pme_en <= cfg_pme_en;
            if (set_ev)      pme_status <= 1'b1;
            else if (clr_ev) pme_status <= 1'b0;
        end
    end

    always_comb pme_n = !(pme_en && pme_status);

    assert_pme_needs_en_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !pme_n |-> pme_en);
    assert_status_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (pme_status && !(cfg_wr && cfg_pme_clr)) |=> pme_status);
    assert_disabled_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!pme_en && !pme_status) |=> !pme_status);
    assert_uninit_no_wake_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_D0U && !pme_status) |=> !pme_status);
endmodule

// File: rtl/txn_gate.sv
module txn_gate
    import pwr_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  pstate_e state,
    input  logic    txn_req,
    input  logic    txn_cfg,
    output logic    txn_accept
);
    logic full_pwr;

    always_comb begin
        full_pwr   = (state == PS_D0U) || (state == PS_D0A);
        txn_accept = txn_req && (txn_cfg ? (state != PS_D3C) : full_pwr);
    end

    assert_accept_needs_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        txn_accept |-> txn_req);
    assert_low_power_cfg_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_accept && !txn_cfg) |-> (state == PS_D0U || state == PS_D0A));
endmodule

// File: rtl/pwr_state_ctrl.sv
module pwr_state_ctrl
    import pwr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       main_pwr,
    input  logic       aux_pwr,
    input  logic       cfg_wr,
    input  logic [1:0] cfg_pstate,
    input  logic       cfg_pme_en,
    input  logic       cfg_pme_clr,
    input  logic       bar_wr,
    input  logic       link_chg,
    input  logic       pkt_match,
    input  logic       txn_req,
    input  logic       txn_cfg,
    output logic       txn_accept,
    output logic [2:0] pwr_state,
    output logic       pme_en,
    output logic       pme_status,
    output logic       pme_n
);
    localparam int N_SRC = 2;

    pstate_e          state;
    logic [N_SRC-1:0] wake_src;

    assign wake_src  = {pkt_match, link_chg};
    assign pwr_state = state;

    pwr_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .main_pwr (main_pwr),
        .cfg_wr   (cfg_wr),
        .cfg_code (cfg_pstate),
        .bar_wr   (bar_wr),
        .state    (state)
    );

    pme_ctrl #(.N_SRC(N_SRC)) u_pme (
        .clk         (clk),
        .rst_n       (rst_n),
        .aux_pwr     (aux_pwr),
        .state       (state),
        .cfg_wr      (cfg_wr),
        .cfg_pme_en  (cfg_pme_en),
        .cfg_pme_clr (cfg_pme_clr),
        .wake_src    (wake_src),
        .pme_en      (pme_en),
        .pme_status  (pme_status),
        .pme_n       (pme_n)
    );

    txn_gate u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .state      (state),
        .txn_req    (txn_req),
        .txn_cfg    (txn_cfg),
        .txn_accept (txn_accept)
    );
endmodule

// File: tb/pwr_state_ctrl_test.sv
module pwr_state_ctrl_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0, main_pwr = 1'b1, aux_pwr = 1'b0;
    logic cfg_wr = 1'b0, cfg_pme_en = 1'b0, cfg_pme_clr = 1'b0;
    logic [1:0] cfg_pstate = 2'd0;
    logic bar_wr = 1'b0, link_chg = 1'b0, pkt_match = 1'b0;
    logic txn_req = 1'b0, txn_cfg = 1'b0;
    logic txn_accept, pme_en, pme_status, pme_n;
    logic [2:0] pwr_state;
    int nchk = 0, nfail = 0;

    always #5 clk = ~clk;

    pwr_state_ctrl uut (.*);

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic aux);
        @(negedge clk);
        rst_n = 1'b0; aux_pwr = aux; main_pwr = 1'b1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic cfg_write(input logic [1:0] code, input logic en, input logic clr);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_pstate = code; cfg_pme_en = en; cfg_pme_clr = clr;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_pme_clr = 1'b0;
    endtask

    task automatic pulse_bar();
        @(negedge clk); bar_wr = 1'b1;
        @(negedge clk); bar_wr = 1'b0;
    endtask

    task automatic pulse_wake(input logic lnk, input logic pkt);
        @(negedge clk); link_chg = lnk; pkt_match = pkt;
        @(negedge clk); link_chg = 1'b0; pkt_match = 1'b0;
    endtask

    task automatic probe_txn(input logic is_cfg, input int exp, input string req);
        txn_req = 1'b1; txn_cfg = is_cfg; #1;
        chk(req, txn_accept, exp);
        txn_req = 1'b0; #1;
        chk(req, txn_accept, 0);
    endtask

    task automatic t_reset();
        do_reset(1'b0);
        chk("R1 state", pwr_state, 0);
        chk("R1 pme_n", pme_n, 1);
        chk("R1 pme_en", pme_en, 0);
        chk("R1 pme_status", pme_status, 0);
    endtask

    task automatic t_bar();
        probe_txn(1'b0, 1, "R7 mem in D0U");
        cfg_write(2'd0, 1'b0, 1'b0);
        chk("R5 D0 write keeps D0U", pwr_state, 0);
        pulse_bar();
        chk("R3 bar promotes", pwr_state, 1);
        pulse_bar();
        chk("R3 bar in D0A", pwr_state, 1);
    endtask

    task automatic t_down();
        cfg_write(2'd1, 1'b0, 1'b0);
        chk("R4 to D1", pwr_state, 2);
        probe_txn(1'b0, 0, "R7 mem in D1");
        probe_txn(1'b1, 1, "R7 cfg in D1");
        pulse_bar();
        chk("R3 bar in D1", pwr_state, 2);
        cfg_write(2'd2, 1'b0, 1'b0);
        chk("R4 D1 to D2", pwr_state, 3);
        cfg_write(2'd1, 1'b0, 1'b0);
        chk("R4 D2 refuses D1", pwr_state, 3);
        cfg_write(2'd0, 1'b0, 1'b0);
        chk("R5 D2 to D0A", pwr_state, 1);
        cfg_write(2'd3, 1'b0, 1'b0);
        chk("R4 to D3hot", pwr_state, 4);
        cfg_write(2'd1, 1'b0, 1'b0);
        chk("R4 D3hot refuses D1", pwr_state, 4);
        cfg_write(2'd0, 1'b0, 1'b0);
        chk("R5 D3hot to D0U", pwr_state, 0);
        pulse_bar();
        chk("R3 re-promote", pwr_state, 1);
    endtask

    task automatic t_wake();
        pulse_wake(1'b1, 1'b1);
        chk("R12 status", pme_status, 0);
        chk("R12 pme_n", pme_n, 1);
        cfg_write(2'd0, 1'b1, 1'b0);
        chk("R8 enable", pme_en, 1);
        pulse_wake(1'b1, 1'b0);
        chk("R9 link status", pme_status, 1);
        chk("R9 link pme_n", pme_n, 0);
        repeat (3) @(negedge clk);
        chk("R11 held", pme_n, 0);
        cfg_write(2'd0, 1'b1, 1'b1);
        chk("R11 cleared", pme_status, 0);
        chk("R11 pme_n", pme_n, 1);
        cfg_write(2'd1, 1'b1, 1'b0);
        pulse_wake(1'b0, 1'b1);
        chk("R9 packet in D1", pme_n, 0);
        @(negedge clk);
        pkt_match = 1'b1; cfg_wr = 1'b1; cfg_pstate = 2'd1; cfg_pme_en = 1'b1; cfg_pme_clr = 1'b1;
        @(negedge clk);
        pkt_match = 1'b0; cfg_wr = 1'b0; cfg_pme_clr = 1'b0;
        chk("R11 set beats clear", pme_status, 1);
        cfg_write(2'd1, 1'b1, 1'b1);
        chk("R11 clear in D1", pme_status, 0);
    endtask

    task automatic t_uninit();
        cfg_write(2'd3, 1'b1, 1'b0);
        cfg_write(2'd0, 1'b1, 1'b0);
        chk("R5 back to D0U", pwr_state, 0);
        pulse_wake(1'b1, 1'b1);
        chk("R10 D0U ignores", pme_status, 0);
    endtask

    task automatic t_cold();
        cfg_write(2'd3, 1'b1, 1'b0);
        @(negedge clk); main_pwr = 1'b0;
        @(negedge clk);
        chk("R6 D3cold", pwr_state, 5);
        probe_txn(1'b1, 0, "R7 cfg in D3cold");
        cfg_write(2'd0, 1'b0, 1'b0);
        chk("R6 write ignored", pwr_state, 5);
        chk("R8 en kept in D3cold", pme_en, 1);
        pulse_bar();
        chk("R6 bar ignored", pwr_state, 5);
        pulse_wake(1'b1, 1'b0);
        chk("R10 no aux", pme_status, 0);
        @(negedge clk); aux_pwr = 1'b1;
        pulse_wake(1'b1, 1'b0);
        chk("R10 aux wake", pme_n, 0);
    endtask

    task automatic t_aux_reset();
        do_reset(1'b1);
        chk("R2 state", pwr_state, 0);
        chk("R2 status kept", pme_status, 1);
        chk("R2 pme_n kept", pme_n, 0);
        do_reset(1'b0);
        chk("R1 status cleared", pme_status, 0);
        chk("R1 en cleared", pme_en, 0);
        chk("R1 pme_n high", pme_n, 1);
    endtask

    initial begin
        #2_000_000;
        nfail++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        t_reset();
        t_bar();
        t_down();
        t_wake();
        t_uninit();
        t_cold();
        t_aux_reset();
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule